// File: doc/BRIEF.md
# Aliased Timer Control Register Access Decoder

This block serves move-to and move-from system-register requests aimed at the kernel-level timer control register. It also stores that register. The register can be reached through two encodings: a primary one and an alias. The alias differs from the primary encoding only in its op1 field.

For each request, the block looks at the current exception level, the host-mode bit, the nested-virtualization bit and a flag that says whether the hypervisor level is enabled. From these it picks one outcome:

- access the local storage,
- hand the access over to the hypervisor timer control register (kept elsewhere), which the block flags and does not carry out,
- report an undefined instruction, or
- raise a trap to the hypervisor level with a fixed syndrome class.

A request is presented for one cycle with `req_valid`. Its response appears on the registered outputs in the next cycle. Only the low ten bits of the register are implemented: timer access enables, event stream enable, edge direction and bit select.

Top module: `tkc_access_decoder`

## Requirements
- R1: After reset, all ten implemented register bits are 0, including the event-enable bit at position 2. All response outputs are 0.
- R2: A matching request with `cur_el` = 0 (either encoding) gives `rsp_undef` = 1 and leaves the register unchanged.
- R3: A primary-encoding request (op0=2'b11, op1=3'b000, CRn=4'b1110, CRm=4'b0001, op2=3'b000) from level 1 or level 3 writes the register, or returns its contents on `rsp_rdata`.
- R4: A primary-encoding request from level 2 with `host_mode` = 1 gives `rsp_redirect` = 1, returns zero data and leaves the register unchanged. With `host_mode` = 0 it accesses the register.
- R5: An alias request (op1=3'b101, other fields as in R3) from level 1 traps when `hyp_enabled` and `nested_virt` are both 1. The trap gives `rsp_trap` = 1 and `rsp_trap_class` = 6'h18 and does not write. In every other case the request is undefined.
- R6: An alias request from level 2 or level 3 accesses the register only when `hyp_enabled` and `host_mode` are both 1. Otherwise it is undefined.
- R7: A write ignores data bits 63:10. A read returns zero in bits 63:10 and the stored value in bits 9:0.
- R8: A request whose encoding matches neither form gives `rsp_valid` = 0, no flags and zero data, and leaves the register unchanged.
- R9: The response is valid exactly one cycle after the request. At most one of `rsp_undef`, `rsp_trap` and `rsp_redirect` is set. Write responses and non-access outcomes return zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_wdata | input | 64 | Write data |
| cur_el | input | 2 | Current exception level 0..3 |
| host_mode | input | 1 | Hypervisor host-mode bit |
| nested_virt | input | 1 | Nested-virtualization bit |
| hyp_enabled | input | 1 | Hypervisor level enabled |
| rsp_valid | output | 1 | Response for a matching request |
| rsp_rdata | output | 64 | Read data |
| rsp_undef | output | 1 | Undefined-instruction outcome |
| rsp_trap | output | 1 | Trap-to-hypervisor outcome |
| rsp_trap_class | output | 6 | Syndrome class of the trap |
| rsp_redirect | output | 1 | Access belongs to the hypervisor timer control register |

## Verification
The hardest cases to see from the ports are the outcomes that must not touch storage: a trapped alias write, a redirected level-2 write, a level-0 write and an unmatched encoding. None of them changes any output directly. To expose them, each such write carries a value that differs from the stored one, and it is followed by a plain level-1 read of the register. Every combination of hypervisor-enabled, host-mode and nested-virtualization bits that flips an alias outcome is driven separately.

// File: rtl/tkc_pkg.sv
package tkc_pkg;
   typedef enum logic [2:0] {
      RT_NONE,
      RT_KERNEL,
      RT_REDIRECT,
      RT_UNDEF,
      RT_TRAP
   } route_e;

   localparam logic [1:0] LVL_USER  = 2'd0;
   localparam logic [1:0] LVL_KERN  = 2'd1;
   localparam logic [1:0] LVL_HYP   = 2'd2;
   localparam logic [1:0] LVL_MON   = 2'd3;
endpackage

// File: rtl/tkc_enc_match.sv
module tkc_enc_match #(
   parameter logic [1:0] OP0_V   = 2'b11,
   parameter logic [2:0] OP1_PRI = 3'b000,
   parameter logic [2:0] OP1_ALT = 3'b101,
   parameter logic [3:0] CRN_V   = 4'b1110,
   parameter logic [3:0] CRM_V   = 4'b0001,
   parameter logic [2:0] OP2_V   = 3'b000
) (
   input  logic [1:0] op0,
   input  logic [2:0] op1,
   input  logic [3:0] crn,
   input  logic [3:0] crm,
   input  logic [2:0] op2,
   output logic       hit_pri,
   output logic       hit_alt
);
   logic common;

   generate
      if (OP1_PRI == OP1_ALT) begin : g_bad_alias
         $error("primary and alias op1 values must differ");
      end
   endgenerate

   always_comb begin
      common  = (op0 == OP0_V) && (crn == CRN_V) && (crm == CRM_V) && (op2 == OP2_V);
      hit_pri = common && (op1 == OP1_PRI);
      hit_alt = common && (op1 == OP1_ALT);
   end
endmodule

// File: rtl/tkc_route.sv
module tkc_route
   import tkc_pkg::*;
(
   input  logic       hit_pri,
   input  logic       hit_alt,
   input  logic [1:0] lvl,
   input  logic       host_mode,
   input  logic       nested_virt,
   input  logic       hyp_enabled,
   output route_e     route
);
   always_comb begin
      route = RT_NONE;
      if (hit_pri || hit_alt) begin
         if (lvl == LVL_USER) begin
            route = RT_UNDEF;
         end else if (hit_pri) begin
            if (lvl == LVL_HYP && host_mode) route = RT_REDIRECT;
            else                             route = RT_KERNEL;
         end else if (lvl == LVL_KERN) begin
            if (hyp_enabled && nested_virt) route = RT_TRAP;
            else                            route = RT_UNDEF;
         end else begin
            if (hyp_enabled && host_mode) route = RT_KERNEL;
            else                          route = RT_UNDEF;
         end
      end
   end
endmodule

// File: rtl/tkc_store.sv
module tkc_store #(
   parameter int                  DATA_W = 64,
   parameter int                  IMPL_W = 10,
   parameter logic [IMPL_W-1:0]   RST_V  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [IMPL_W-1:0] q;

   always_ff @(posedge clk) begin
      if (!rst_n)     q <= RST_V;
      else if (wr_en) q <= wdata[IMPL_W-1:0];
   end

   generate
      if (IMPL_W == DATA_W) begin : g_full
         assign rdata = q;
      end else begin : g_pad
         logic unused_hi;
         assign unused_hi = ^wdata[DATA_W-1:IMPL_W];
         assign rdata     = {{(DATA_W-IMPL_W){1'b0}}, q};
      end
   endgenerate

   // R4 / R8: contents move only on an enabled write
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(q))
      else $error("register changed without write enable");
endmodule

// File: rtl/tkc_access_decoder.sv
module tkc_access_decoder
   import tkc_pkg::*;
#(
   parameter int                 DATA_W   = 64,
   parameter int                 IMPL_W   = 10,
   parameter int                 EC_W     = 6,
   parameter logic [EC_W-1:0]    TRAP_EC  = 6'h18,
   parameter logic [2:0]         OP1_PRI  = 3'b000,
   parameter logic [2:0]         OP1_ALT  = 3'b101
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_op0,
   input  logic [2:0]        req_op1,
   input  logic [3:0]        req_crn,
   input  logic [3:0]        req_crm,
   input  logic [2:0]        req_op2,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [1:0]        cur_el,
   input  logic              host_mode,
   input  logic              nested_virt,
   input  logic              hyp_enabled,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_undef,
   output logic              rsp_trap,
   output logic [EC_W-1:0]   rsp_trap_class,
   output logic              rsp_redirect
);
   localparam int PAD_W = DATA_W - IMPL_W;

   generate
      if (IMPL_W < 3 || IMPL_W > DATA_W) begin : g_bad_width
         $error("IMPL_W must lie between 3 and DATA_W");
      end
   endgenerate

   logic              hit_pri, hit_alt;
   route_e            route;
   logic              wr_en;
   logic [DATA_W-1:0] store_rd;

   tkc_enc_match #(.OP1_PRI(OP1_PRI), .OP1_ALT(OP1_ALT)) u_match (
      .op0(req_op0), .op1(req_op1), .crn(req_crn), .crm(req_crm), .op2(req_op2),
      .hit_pri(hit_pri), .hit_alt(hit_alt)
   );

   tkc_route u_route (
      .hit_pri(hit_pri), .hit_alt(hit_alt), .lvl(cur_el),
      .host_mode(host_mode), .nested_virt(nested_virt), .hyp_enabled(hyp_enabled),
      .route(route)
   );

   assign wr_en = req_valid && req_write && (route == RT_KERNEL);

   tkc_store #(.DATA_W(DATA_W), .IMPL_W(IMPL_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(req_wdata), .rdata(store_rd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid      <= 1'b0;
         rsp_rdata      <= '0;
         rsp_undef      <= 1'b0;
         rsp_trap       <= 1'b0;
         rsp_trap_class <= '0;
         rsp_redirect   <= 1'b0;
      end else begin
         rsp_valid      <= req_valid && (hit_pri || hit_alt);
         rsp_rdata      <= (req_valid && !req_write && route == RT_KERNEL) ? store_rd : '0;
         rsp_undef      <= req_valid && (route == RT_UNDEF);
         rsp_trap       <= req_valid && (route == RT_TRAP);
         rsp_trap_class <= (req_valid && route == RT_TRAP) ? TRAP_EC : '0;
         rsp_redirect   <= req_valid && (route == RT_REDIRECT);
      end
   end

   // R9: outcomes are mutually exclusive
   p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_undef, rsp_trap, rsp_redirect}))
      else $error("more than one outcome flag");

   // R5: a trap always carries the fixed syndrome class
   p_trap_class_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_trap |-> (rsp_trap_class == TRAP_EC))
      else $error("trap class wrong");

   // R2: level-0 access to either encoding is undefined
   p_user_undef_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (hit_pri || hit_alt) && cur_el == LVL_USER) |=> rsp_undef)
      else $error("user-level access not undefined");

   // R8: unmatched encodings give no response
   p_nomatch_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !hit_pri && !hit_alt) |=> !rsp_valid)
      else $error("response for unmatched encoding");

   // R7: reserved upper bits read as zero
   generate
      if (PAD_W > 0) begin : g_hi_chk
         p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_rdata[DATA_W-1:IMPL_W] == '0)
            else $error("reserved bits nonzero");
      end
   endgenerate
endmodule

// File: tb/tkc_access_decoder_test.sv
`timescale 1ns/1ps
module tkc_access_decoder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [1:0]  req_op0 = 2'b11;
   logic [2:0]  req_op1 = 3'b000;
   logic [3:0]  req_crn = 4'b1110, req_crm = 4'b0001;
   logic [2:0]  req_op2 = 3'b000;
   logic [63:0] req_wdata = '0;
   logic [1:0]  cur_el = 2'd1;
   logic        host_mode = 1'b0, nested_virt = 1'b0, hyp_enabled = 1'b0;
   logic        rsp_valid, rsp_undef, rsp_trap, rsp_redirect;
   logic [63:0] rsp_rdata;
   logic [5:0]  rsp_trap_class;

   int checks = 0;
   int errors = 0;
   logic [9:0] model = '0;

   localparam logic [2:0] PRI = 3'b000;
   localparam logic [2:0] ALT = 3'b101;

   always #10 clk = ~clk;

   tkc_access_decoder uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
      .req_op2(req_op2), .req_wdata(req_wdata), .cur_el(cur_el),
      .host_mode(host_mode), .nested_virt(nested_virt), .hyp_enabled(hyp_enabled),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_undef(rsp_undef),
      .rsp_trap(rsp_trap), .rsp_trap_class(rsp_trap_class), .rsp_redirect(rsp_redirect)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // drive one request at a falling edge, sample the registered response one cycle later
   task automatic issue(input logic wr, input logic [1:0] lvl, input logic [2:0] op1,
                        input logic [63:0] wd, input logic hm, input logic nv, input logic he);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; cur_el = lvl; req_op1 = op1; req_wdata = wd;
      host_mode = hm; nested_virt = nv; hyp_enabled = he;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   // expected response: {valid, undef, trap, redirect}, data, trap class
   task automatic expect_rsp(input string tag, input logic [3:0] fl, input logic [63:0] d);
      chk({tag, " flags"}, {60'd0, rsp_valid, rsp_undef, rsp_trap, rsp_redirect}, {60'd0, fl});
      chk({tag, " data"}, rsp_rdata, d);
      chk({tag, " class"}, {58'd0, rsp_trap_class}, {58'd0, (fl[1] ? 6'h18 : 6'h00)});
   endtask

   task automatic read_back(input string tag);
      issue(1'b0, 2'd1, PRI, '0, 1'b0, 1'b0, 1'b0);
      expect_rsp(tag, 4'b1000, {54'd0, model});
   endtask

   task automatic t_reset;
      chk("R1 reset valid", {63'd0, rsp_valid}, 64'd0);
      chk("R1 reset flags", {61'd0, rsp_undef, rsp_trap, rsp_redirect}, 64'd0);
      read_back("R1 reset contents");
   endtask

   task automatic t_direct;
      issue(1'b1, 2'd1, PRI, 64'h3FF, 1'b0, 1'b0, 1'b0);
      model = 10'h3FF;
      expect_rsp("R3 write lvl1", 4'b1000, '0);
      read_back("R3 read lvl1");
      issue(1'b1, 2'd3, PRI, 64'h155, 1'b1, 1'b1, 1'b1);
      model = 10'h155;
      expect_rsp("R3 write lvl3", 4'b1000, '0);
      issue(1'b0, 2'd3, PRI, '0, 1'b0, 1'b0, 1'b0);
      expect_rsp("R3 read lvl3", 4'b1000, 64'h155);
      @(negedge clk);
      chk("R9 valid drops", {63'd0, rsp_valid}, 64'd0);
   endtask

   task automatic t_reserved;
      issue(1'b1, 2'd1, PRI, 64'hFFFF_FFFF_FFFF_FC2A, 1'b0, 1'b0, 1'b0);
      model = 10'h02A;
      read_back("R7 reserved bits");
   endtask

   task automatic t_user;
      issue(1'b1, 2'd0, PRI, 64'h3C3, 1'b0, 1'b0, 1'b1);
      expect_rsp("R2 user primary", 4'b1100, '0);
      issue(1'b1, 2'd0, ALT, 64'h3C3, 1'b1, 1'b1, 1'b1);
      expect_rsp("R2 user alias", 4'b1100, '0);
      read_back("R2 unchanged");
   endtask

   task automatic t_hyp_primary;
      issue(1'b1, 2'd2, PRI, 64'h111, 1'b1, 1'b0, 1'b1);
      expect_rsp("R4 redirect write", 4'b1001, '0);
      issue(1'b0, 2'd2, PRI, '0, 1'b1, 1'b0, 1'b1);
      expect_rsp("R4 redirect read", 4'b1001, '0);
      read_back("R4 unchanged");
      issue(1'b1, 2'd2, PRI, 64'h0AA, 1'b0, 1'b0, 1'b1);
      model = 10'h0AA;
      expect_rsp("R4 local write", 4'b1000, '0);
      read_back("R4 local readback");
   endtask

   task automatic t_alias_kern;
      issue(1'b1, 2'd1, ALT, 64'h301, 1'b0, 1'b1, 1'b1);
      expect_rsp("R5 trap", 4'b1010, '0);
      read_back("R5 trap no write");
      issue(1'b0, 2'd1, ALT, '0, 1'b0, 1'b1, 1'b0);
      expect_rsp("R5 disabled undef", 4'b1100, '0);
      issue(1'b1, 2'd1, ALT, 64'h301, 1'b1, 1'b0, 1'b1);
      expect_rsp("R5 no nv undef", 4'b1100, '0);
      read_back("R5 unchanged");
   endtask

   task automatic t_alias_upper;
      issue(1'b1, 2'd2, ALT, 64'h2C3, 1'b1, 1'b0, 1'b1);
      model = 10'h2C3;
      expect_rsp("R6 lvl2 write", 4'b1000, '0);
      issue(1'b0, 2'd3, ALT, '0, 1'b1, 1'b0, 1'b1);
      expect_rsp("R6 lvl3 read", 4'b1000, 64'h2C3);
      issue(1'b1, 2'd2, ALT, 64'h011, 1'b1, 1'b0, 1'b0);
      expect_rsp("R6 disabled undef", 4'b1100, '0);
      issue(1'b1, 2'd3, ALT, 64'h011, 1'b0, 1'b1, 1'b1);
      expect_rsp("R6 no host undef", 4'b1100, '0);
      read_back("R6 unchanged");
   endtask

   task automatic t_nomatch;
      issue(1'b1, 2'd1, 3'b001, 64'h0F0, 1'b1, 1'b1, 1'b1);
      expect_rsp("R8 bad op1", 4'b0000, '0);
      req_op2 = 3'b001;
      issue(1'b0, 2'd0, PRI, '0, 1'b0, 1'b0, 1'b0);
      expect_rsp("R8 bad op2", 4'b0000, '0);
      req_op2 = 3'b000;
      read_back("R8 unchanged");
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_direct();
      t_reserved();
      t_user();
      t_hyp_primary();
      t_alias_kern();
      t_alias_upper();
      t_nomatch();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule